// File: doc/BRIEF.md
# Tagged TLB Invalidate Walker

This block holds a small software-managed translation buffer and walks a range of its entries, setting a per-entry hardware-invalid bit on each entry that meets the selection rule of the command. Two commands exist: a tagged invalidate that compares each entry's address-space identifier with the current one and spares global entries, and a flush that invalidates every entry of the range whatever its identifier or global bit. Either command can be narrowed further to entries whose stored virtual-machine identifier equals the root value.

The walk range is chosen from the MMU organisation. A single joint array of `VTLB_N` entries is walked in full. A split organisation has a fully associative part of `VTLB_N` entries followed by `FTLB_SETS` sets of `FTLB_WAYS_FIELD + 2` ways each. With a software-driven walk the command index picks either the whole associative part or one set. With a hardware-driven walk one command covers the whole array. One entry is visited per clock.

Entries are loaded through a plain write port and their invalid bits are read back through an asynchronous read port, so the effect of every walk is visible at the ports.

Top module: `tlb_inval_walker`

## Requirements
- R1: A tagged invalidate (`cmd_flush`=0) sets the invalid bit of an in-range entry only when the entry's ASID equals `cur_asid` and its global bit is 0; other entries keep their invalid bit.
- R2: A flush (`cmd_flush`=1) sets the invalid bit of every in-range entry, whatever its ASID and global bit.
- R3: With `gid_en`=1, an entry is invalidated only if, in addition, its stored guest identifier equals `root_gid`; with `gid_en`=0 the guest identifier is not compared.
- R4: Unless `mmu_kind`=4 with `walk_mode` 2 or 3, the walk covers entries 0 to `VTLB_N`-1 (entry 0 included, no wired boundary), `cmd_index` is ignored and entries above `VTLB_N`-1 are untouched.
- R5: With `mmu_kind`=4 and `walk_mode`=2, an index of `VTLB_N`-1 or less walks entries 0 to `VTLB_N`-1 only.
- R6: With `mmu_kind`=4 and `walk_mode`=2, an index of `VTLB_N` or more walks only set s = min((index-`VTLB_N`) div W, `FTLB_SETS`-1), i.e. entries `VTLB_N`+s·W to `VTLB_N`+s·W+W-1, where W = `FTLB_WAYS_FIELD`+2.
- R7: With `mmu_kind`=4 and `walk_mode`=3, one command walks all `VTLB_N`+W·`FTLB_SETS` entries and the index is ignored.
- R8: A command accepted with `cp0_en`=0 raises `cu_err` for exactly the one cycle after the accepting edge, never raises `busy` or `done`, and changes no invalid bit.
- R9: After an accepting edge with `cp0_en`=1, `busy` is high for exactly as many cycles as the range has entries, and `done` is high for the single cycle after `busy` falls.
- R10: A `cmd_valid` that arrives while `busy` is high is dropped: the running walk keeps its range and no second walk follows.
- R11: After reset every invalid bit is 1 and `busy`, `done`, `cu_err` are 0; a write stores the entry's ASID, global bit and guest identifier and clears its invalid bit, and invalid bits otherwise fall only through a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_flush | input | 1 | 1 = flush, 0 = tagged invalidate |
| cmd_index | input | IDXW | Index that selects the range in software-walk mode |
| cur_asid | input | ASID_W | Current address-space identifier |
| root_gid | input | GID_W | Root guest identifier compared against entries |
| gid_en | input | 1 | Enables guest-identifier qualification |
| cp0_en | input | 1 | Coprocessor access enable |
| mmu_kind | input | 3 | MMU organisation: 4 = split, any other = joint |
| walk_mode | input | 2 | Split walk mode: 2 = software, 3 = hardware |
| wr_en | input | 1 | Entry write strobe, ignored while busy |
| wr_idx | input | IDXW | Entry to write |
| wr_asid | input | ASID_W | ASID to store |
| wr_global | input | 1 | Global bit to store |
| wr_gid | input | GID_W | Guest identifier to store |
| rd_idx | input | IDXW | Entry whose invalid bit is read |
| rd_inv | output | 1 | Invalid bit of entry `rd_idx` (combinational) |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse after the last visit |
| cu_err | output | 1 | Coprocessor-unusable pulse |

## Verification
A command is taken at a rising edge; `cu_err` is due in the very next cycle, `busy` stays high for n cycles counted from that edge, and `done` appears in the cycle where `busy` has just dropped, with the last invalid bit already updated. The bench drives on falling edges and samples on falling edges, counting the falling edges that see `busy` high and comparing the count with the range size it computes itself. Invalid bits are read back only after `done` has gone low again, through the combinational read port, and compared entry by entry with a bench model.

// File: rtl/tlbw_pkg.sv
package tlbw_pkg;

  localparam logic [2:0] MMU_SPLIT = 3'd4;
  localparam logic [1:0] WALK_SW   = 2'd2;
  localparam logic [1:0] WALK_HW   = 2'd3;

  typedef enum logic [1:0] {
    RG_JOINT = 2'd0,
    RG_VTLB  = 2'd1,
    RG_FSET  = 2'd2,
    RG_ALL   = 2'd3
  } range_kind_e;

  // Which kind of range a command walks.
  function automatic range_kind_e classify(input logic [2:0] kind, input logic [1:0] mode,
                                           input int idx, input int vtlb_n);
    if (kind == MMU_SPLIT && mode == WALK_HW) return RG_ALL;
    if (kind == MMU_SPLIT && mode == WALK_SW) return (idx < vtlb_n) ? RG_VTLB : RG_FSET;
    return RG_JOINT;
  endfunction

  // Set addressed by an index in the set-indexed region, clamped to the last set.
  function automatic int ftlb_set(input int idx, input int vtlb_n, input int ways, input int sets);
    int s;
    if (idx < vtlb_n) return 0;
    s = (idx - vtlb_n) / ways;
    if (s > sets - 1) s = sets - 1;
    return s;
  endfunction

  function automatic int range_lo(input range_kind_e rk, input int set, input int vtlb_n,
                                  input int ways);
    if (rk == RG_FSET) return vtlb_n + set * ways;
    return 0;
  endfunction

  function automatic int range_hi(input range_kind_e rk, input int set, input int vtlb_n,
                                  input int ways, input int total);
    case (rk)
      RG_ALL:  return total - 1;
      RG_FSET: return vtlb_n + set * ways + ways - 1;
      default: return vtlb_n - 1;
    endcase
  endfunction

endpackage

// File: rtl/tlbw_store.sv
module tlbw_store #(
  parameter int N      = 24,
  parameter int IDXW   = 5,
  parameter int ASID_W = 8,
  parameter int GID_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDXW-1:0]   wr_idx,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  logic [GID_W-1:0]  wr_gid,
  input  logic              kill_en,
  input  logic [IDXW-1:0]   kill_idx,
  input  logic [IDXW-1:0]   look_idx,
  output logic [ASID_W-1:0] look_asid,
  output logic              look_global,
  output logic [GID_W-1:0]  look_gid,
  input  logic [IDXW-1:0]   rd_idx,
  output logic              rd_inv
);

  logic [ASID_W-1:0] asid_a [N];
  logic [GID_W-1:0]  gid_a  [N];
  logic [N-1:0]      glb_q;
  logic [N-1:0]      inv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        asid_a[i] <= '0;
        gid_a[i]  <= '0;
      end
      glb_q <= '0;
      inv_q <= '1;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (wr_en && wr_idx == IDXW'(i)) begin
          asid_a[i] <= wr_asid;
          gid_a[i]  <= wr_gid;
          glb_q[i]  <= wr_global;
          inv_q[i]  <= 1'b0;
        end else if (kill_en && kill_idx == IDXW'(i)) begin
          inv_q[i]  <= 1'b1;
        end
      end
    end
  end

  assign look_asid   = asid_a[look_idx];
  assign look_gid    = gid_a[look_idx];
  assign look_global = glb_q[look_idx];
  assign rd_inv      = inv_q[rd_idx];

  // An invalid bit may drop only through a write.
  assert_inv_clear_by_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (($past(inv_q) & ~inv_q) == '0));

  // Without a kill from the walker, no invalid bit rises.
  assert_no_kill_no_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !kill_en |=> ((inv_q & ~$past(inv_q)) == '0));

endmodule

// File: rtl/tlbw_match.sv
module tlbw_match #(
  parameter int ASID_W = 8,
  parameter int GID_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              flush_in,
  input  logic [ASID_W-1:0] asid_in,
  input  logic [GID_W-1:0]  gid_in,
  input  logic              gid_en_in,
  input  logic [ASID_W-1:0] e_asid,
  input  logic              e_global,
  input  logic [GID_W-1:0]  e_gid,
  output logic              hit
);

  logic              q_flush;
  logic [ASID_W-1:0] q_asid;
  logic [GID_W-1:0]  q_gid;
  logic              q_gid_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_flush  <= 1'b0;
      q_asid   <= '0;
      q_gid    <= '0;
      q_gid_en <= 1'b0;
    end else if (load) begin
      q_flush  <= flush_in;
      q_asid   <= asid_in;
      q_gid    <= gid_in;
      q_gid_en <= gid_en_in;
    end
  end

  logic tag_ok, gid_ok;
  always_comb begin
    tag_ok = q_flush || (e_asid == q_asid && !e_global);
    gid_ok = !q_gid_en || (e_gid == q_gid);
    hit    = tag_ok && gid_ok;
  end

  assert_global_spared_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_flush && e_global) |-> !hit);

  assert_gid_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (q_gid_en && e_gid != q_gid) |-> !hit);

endmodule

// File: rtl/tlbw_ctrl.sv
module tlbw_ctrl
  import tlbw_pkg::*;
#(
  parameter int VTLB_N = 8,
  parameter int WAYS   = 4,
  parameter int SETS   = 4,
  parameter int TOTAL  = 24,
  parameter int IDXW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [IDXW-1:0] cmd_index,
  input  logic            cp0_en,
  input  logic [2:0]      mmu_kind,
  input  logic [1:0]      walk_mode,
  output logic            start,
  output logic            busy,
  output logic            done,
  output logic            cu_err,
  output logic [IDXW-1:0] ptr
);

  logic [IDXW-1:0] ptr_q, last_q;
  logic            busy_q, done_q, cu_q;
  range_kind_e     rk;
  int              set_i;
  logic [IDXW-1:0] lo_w, hi_w;
  logic            accept, at_last;

  always_comb begin
    rk    = classify(mmu_kind, walk_mode, int'(cmd_index), VTLB_N);
    set_i = ftlb_set(int'(cmd_index), VTLB_N, WAYS, SETS);
    lo_w  = IDXW'(range_lo(rk, set_i, VTLB_N, WAYS));
    hi_w  = IDXW'(range_hi(rk, set_i, VTLB_N, WAYS, TOTAL));
  end

  assign accept  = cmd_valid && !busy_q;
  assign start   = accept && cp0_en;
  assign at_last = busy_q && (ptr_q == last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      last_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cu_q   <= 1'b0;
    end else begin
      done_q <= at_last;
      cu_q   <= accept && !cp0_en;
      if (start) begin
        busy_q <= 1'b1;
        ptr_q  <= lo_w;
        last_q <= hi_w;
      end else if (busy_q) begin
        if (at_last) busy_q <= 1'b0;
        else         ptr_q  <= ptr_q + 1'b1;
      end
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign cu_err = cu_q;
  assign ptr    = ptr_q;

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);

  assert_ptr_in_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (ptr_q <= last_q));

  assert_cu_no_walk_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy_q && !cp0_en) |=> (cu_q && !busy_q));

  assert_range_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !at_last) |=> (busy_q && $stable(last_q)));

endmodule

// File: rtl/tlb_inval_walker.sv
module tlb_inval_walker #(
  parameter int VTLB_N          = 8,
  parameter int FTLB_WAYS_FIELD = 2,
  parameter int FTLB_SETS       = 4,
  parameter int ASID_W          = 8,
  parameter int GID_W           = 4,
  localparam int WAYS  = FTLB_WAYS_FIELD + 2,
  localparam int TOTAL = VTLB_N + WAYS * FTLB_SETS,
  localparam int IDXW  = $clog2(TOTAL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_flush,
  input  logic [IDXW-1:0]   cmd_index,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic [GID_W-1:0]  root_gid,
  input  logic              gid_en,
  input  logic              cp0_en,
  input  logic [2:0]        mmu_kind,
  input  logic [1:0]        walk_mode,
  input  logic              wr_en,
  input  logic [IDXW-1:0]   wr_idx,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  logic [GID_W-1:0]  wr_gid,
  input  logic [IDXW-1:0]   rd_idx,
  output logic              rd_inv,
  output logic              busy,
  output logic              done,
  output logic              cu_err
);

  logic              start, hit, kill_en, wr_gated;
  logic [IDXW-1:0]   ptr;
  logic [ASID_W-1:0] e_asid;
  logic              e_global;
  logic [GID_W-1:0]  e_gid;

  tlbw_ctrl #(
    .VTLB_N(VTLB_N), .WAYS(WAYS), .SETS(FTLB_SETS), .TOTAL(TOTAL), .IDXW(IDXW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_index(cmd_index),
    .cp0_en(cp0_en), .mmu_kind(mmu_kind), .walk_mode(walk_mode),
    .start(start), .busy(busy), .done(done), .cu_err(cu_err), .ptr(ptr)
  );

  tlbw_match #(.ASID_W(ASID_W), .GID_W(GID_W)) u_match (
    .clk(clk), .rst_n(rst_n), .load(start), .flush_in(cmd_flush),
    .asid_in(cur_asid), .gid_in(root_gid), .gid_en_in(gid_en),
    .e_asid(e_asid), .e_global(e_global), .e_gid(e_gid), .hit(hit)
  );

  assign kill_en  = busy && hit;
  assign wr_gated = wr_en && !busy;

  tlbw_store #(.N(TOTAL), .IDXW(IDXW), .ASID_W(ASID_W), .GID_W(GID_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_gated), .wr_idx(wr_idx), .wr_asid(wr_asid), .wr_global(wr_global),
    .wr_gid(wr_gid), .kill_en(kill_en), .kill_idx(ptr), .look_idx(ptr),
    .look_asid(e_asid), .look_global(e_global), .look_gid(e_gid),
    .rd_idx(rd_idx), .rd_inv(rd_inv)
  );

  // Entries are only ever invalidated inside a walk.
  assert_kill_inside_walk_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !kill_en);

endmodule

// File: tb/sim_tlb_inval_walker.sv
`timescale 1ns/1ps
module sim_tlb_inval_walker;

  localparam int V = 8;
  localparam int W = 4;
  localparam int S = 4;
  localparam int T = V + W * S;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 0, cmd_flush = 0, gid_en = 0, cp0_en = 1;
  logic [4:0] cmd_index = '0;
  logic [7:0] cur_asid = '0;
  logic [3:0] root_gid = '0;
  logic [2:0] mmu_kind = 3'd1;
  logic [1:0] walk_mode = 2'd0;
  logic       wr_en = 0, wr_global = 0;
  logic [4:0] wr_idx = '0, rd_idx = '0;
  logic [7:0] wr_asid = '0;
  logic [3:0] wr_gid = '0;
  logic       rd_inv, busy, done, cu_err;

  int total = 0, bad = 0;

  logic [7:0] m_asid [T];
  logic [3:0] m_gid  [T];
  logic       m_g    [T];
  logic       m_inv  [T];

  always #2 clk = ~clk;

  tlb_inval_walker u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_flush(cmd_flush),
    .cmd_index(cmd_index), .cur_asid(cur_asid), .root_gid(root_gid), .gid_en(gid_en),
    .cp0_en(cp0_en), .mmu_kind(mmu_kind), .walk_mode(walk_mode),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_asid(wr_asid), .wr_global(wr_global),
    .wr_gid(wr_gid), .rd_idx(rd_idx), .rd_inv(rd_inv),
    .busy(busy), .done(done), .cu_err(cu_err)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Range membership, restated per entry.
  function automatic bit in_range(input int i, input logic [2:0] kind, input logic [1:0] wm,
                                  input int idx);
    int s;
    if (kind == 3'd4 && wm == 2'd3) return 1'b1;
    if (kind == 3'd4 && wm == 2'd2 && idx >= V) begin
      s = (idx - V) / W;
      if (s >= S) s = S - 1;
      return (i >= V) && ((i - V) / W == s);
    end
    return i < V;
  endfunction

  function automatic bit sel(input int i, input bit fl, input logic [7:0] a,
                             input logic [3:0] g, input bit ge);
    bit t;
    t = fl ? 1'b1 : (m_asid[i] == a && !m_g[i]);
    return t && (!ge || m_gid[i] == g);
  endfunction

  task automatic wr(input int i, input logic [7:0] a, input bit g, input logic [3:0] gd);
    @(negedge clk);
    wr_en = 1; wr_idx = 5'(i); wr_asid = a; wr_global = g; wr_gid = gd;
    @(negedge clk);
    wr_en = 0;
    m_asid[i] = a; m_g[i] = g; m_gid[i] = gd; m_inv[i] = 1'b0;
  endtask

  task automatic compare_all(input string tag);
    int miss = 0, first = -1, fa = 0, fe = 0;
    for (int i = 0; i < T; i++) begin
      rd_idx = 5'(i);
      #0.1;
      if (rd_inv !== m_inv[i]) begin
        miss++;
        if (first < 0) begin first = i; fa = int'(rd_inv); fe = int'(m_inv[i]); end
      end
    end
    if (miss != 0) $display("  entry %0d differs (%0d entries)", first, miss);
    check(miss == 0, tag, fa, fe);
  endtask

  task automatic run_cmd(input bit fl, input int idx, input logic [7:0] a, input logic [3:0] g,
                         input bit ge, input bit cp, input logic [2:0] kind,
                         input logic [1:0] wm, input bit poke, input string tag);
    int n_exp = 0, cyc = 0;
    for (int i = 0; i < T; i++) if (in_range(i, kind, wm, idx)) n_exp++;
    @(negedge clk);
    cmd_valid = 1; cmd_flush = fl; cmd_index = 5'(idx); cur_asid = a; root_gid = g;
    gid_en = ge; cp0_en = cp; mmu_kind = kind; walk_mode = wm;
    @(negedge clk);
    cmd_valid = 0;
    if (!cp) begin
      check(cu_err == 1'b1, "R8 cu_err pulse", int'(cu_err), 1);
      check(busy == 1'b0, "R8 no busy", int'(busy), 0);
      @(negedge clk);
      check(cu_err == 1'b0 && done == 1'b0, "R8 cu_err single", int'(cu_err), 0);
    end else begin
      while (busy && cyc < 1000) begin
        cyc++;
        if (poke && cyc == 2) begin
          cmd_valid = 1; cmd_flush = 1; gid_en = 0; mmu_kind = 3'd4; walk_mode = 2'd3;
        end else cmd_valid = 0;
        @(negedge clk);
      end
      cmd_valid = 0;
      check(cyc == n_exp, {tag, " R9 busy length"}, cyc, n_exp);
      check(done == 1'b1, "R9 done after busy", int'(done), 1);
      @(negedge clk);
      check(done == 1'b0 && busy == 1'b0, "R9 R10 done single, no restart",
            int'(done) + 2 * int'(busy), 0);
      for (int i = 0; i < T; i++)
        if (in_range(i, kind, wm, idx) && sel(i, fl, a, g, ge)) m_inv[i] = 1'b1;
    end
    compare_all(tag);
  endtask

  task automatic fill_directed();
    for (int i = 0; i < T; i++)
      wr(i, 8'(i % 3), (i % 5) == 4, 4'(i % 2));
  endtask

  initial begin
    #800000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < T; i++) begin
      m_asid[i] = '0; m_gid[i] = '0; m_g[i] = 1'b0; m_inv[i] = 1'b1;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(busy == 0 && done == 0 && cu_err == 0, "R11 reset outputs",
          int'(busy) + int'(done) + int'(cu_err), 0);
    compare_all("R11 reset all invalid");

    fill_directed();
    compare_all("R11 write clears invalid");

    // R1 tagged, joint, index ignored (R4)
    run_cmd(0, 20, 8'd1, 4'd0, 0, 1, 3'd1, 2'd2, 0, "R1 R4 tagged joint");
    fill_directed();
    // R2 flush, joint organisation with unknown kind
    run_cmd(1, 17, 8'd9, 4'd0, 0, 1, 3'd0, 2'd3, 0, "R2 R4 flush joint");
    fill_directed();
    // R3 guest id qualification
    run_cmd(1, 0, 8'd0, 4'd1, 1, 1, 3'd4, 2'd3, 0, "R3 gid flush all");
    fill_directed();
    run_cmd(0, 0, 8'd2, 4'd0, 1, 1, 3'd1, 2'd0, 0, "R3 gid tagged");
    fill_directed();
    // R5 software walk, associative part (boundary index V-1)
    run_cmd(1, V - 1, 8'd0, 4'd0, 0, 1, 3'd4, 2'd2, 0, "R5 sw vtlb");
    fill_directed();
    // R6 software walk, one set; first set boundary, a mid set, clamp
    run_cmd(1, V, 8'd0, 4'd0, 0, 1, 3'd4, 2'd2, 0, "R6 sw set0");
    fill_directed();
    run_cmd(0, V + 2 * W + 1, 8'd0, 4'd0, 0, 1, 3'd4, 2'd2, 0, "R6 sw set2 tagged");
    fill_directed();
    run_cmd(1, 31, 8'd0, 4'd0, 0, 1, 3'd4, 2'd2, 0, "R6 sw set clamp");
    fill_directed();
    // R7 hardware walk over all entries
    run_cmd(1, 3, 8'd0, 4'd0, 0, 1, 3'd4, 2'd3, 0, "R7 hw all");
    fill_directed();
    // R8 access disabled
    run_cmd(1, 0, 8'd0, 4'd0, 0, 0, 3'd4, 2'd3, 0, "R8 no change");
    // R10 command during walk ignored
    run_cmd(0, 2, 8'd1, 4'd0, 0, 1, 3'd1, 2'd0, 1, "R10 busy ignore");

    for (int k = 0; k < 40; k++) begin
      int nw;
      logic [2:0] kd;
      nw = 2 + int'($urandom % 6);
      for (int j = 0; j < nw; j++)
        wr(int'($urandom % T), 8'($urandom % 4), ($urandom % 4) == 0, 4'($urandom % 3));
      case ($urandom % 4)
        0: kd = 3'd1;
        1: kd = 3'd2;
        default: kd = 3'd4;
      endcase
      run_cmd($urandom % 2 == 1, int'($urandom % T), 8'($urandom % 4), 4'($urandom % 3),
              $urandom % 2 == 1, ($urandom % 8) != 0, kd, 2'(2 + $urandom % 2),
              ($urandom % 5) == 0, "R1 R2 R3 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule